// File: doc/BRIEF.md
# Bus master write command selector

This block sits inside a bus master write engine and picks, for every master write, between a plain Memory Write (MW) and a Memory Write and Invalidate (MWI). A write request gives a start address, a byte count, the cache line size from the configuration space, and the invalidate-enable bit from the command register. The block announces the first burst with its command and address. It then follows the accepted data phases reported by the bus interface.

During a transfer the block keeps a running address and remaining byte count. At every cache line boundary it checks whether the command in use still suits the data that is left. If it does not, it asks the bus interface to stop the burst and announces a new one, with the other command, at the current address. When the target disconnects or the latency timer expires, the bus interface flags the last accepted phase as terminating. The block then makes a fresh decision for the restart. The command and burst address outputs stay constant for the whole of a burst.

Top module: `mwc_cmd_select`

## Requirements
- R1: The cache line size input counts 32-bit words. Only the values 4, 8, 16 and 32 are supported, which give lines of 16, 32, 64 and 128 bytes. For any other value, 0 included, every burst uses MW (`cmd_inv` = 0).
- R2: When `cfg_inv_en` is 0 at the request, every burst of that transfer uses MW.
- R3: One cycle after `req_valid` is seen while idle, `burst_start` pulses with `burst_addr` set to the request address with its low two bits cleared. `cmd_inv` is 1 (MWI) exactly when invalidate is allowed, the address is a multiple of the line size and at least one full line of bytes remains.
- R4: An unaligned start address, or an aligned one with less than one line to transfer, starts with MW.
- R5: If an MWI burst reaches a line boundary with less than a full line left, the block pulses `stop_req` together with `burst_start`, with `cmd_inv` = 0 and `burst_addr` at the boundary.
- R6: If an MW burst reaches a line boundary with at least one full line left and MWI is allowed, the block pulses `stop_req` together with `burst_start`, with `cmd_inv` = 1 and `burst_addr` at the boundary.
- R7: A `phase_ack` with `early_term` high that does not finish the transfer produces a `burst_start` one cycle later, without `stop_req`. The new burst starts at the next address, and its command is decided afresh under the rules of R3 and R4.
- R8: Each accepted phase moves 4 bytes, and the low two bits of `req_bytes` are ignored. `xfer_done` pulses one cycle after the phase that empties the count and `busy` falls in the same cycle. A request with a count of 0 yields only `xfer_done`.
- R9: While `busy` is high, `cmd_inv` and `burst_addr` change only in a cycle where `burst_start` is high.
- R10: After reset, `busy`, `burst_start`, `stop_req`, `xfer_done` and `cmd_inv` are all 0.
- R11: `phase_ack` while idle is ignored. It produces no `burst_start` and no `xfer_done`, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New master write request (taken when idle) |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | LEN_W | Byte count to transfer |
| cfg_line_words | input | CLS_W | Cache line size in 32-bit words |
| cfg_inv_en | input | 1 | Invalidate command allowed |
| phase_ack | input | 1 | One 4-byte data phase accepted |
| early_term | input | 1 | Accepted phase ended the burst (disconnect or latency timeout) |
| busy | output | 1 | Transfer in progress |
| burst_start | output | 1 | A burst begins with `cmd_inv` at `burst_addr` |
| burst_addr | output | ADDR_W | Start address of the current burst |
| cmd_inv | output | 1 | 1 = Memory Write and Invalidate, 0 = Memory Write |
| stop_req | output | 1 | Block asks the current burst to end for a command switch |
| xfer_done | output | 1 | Transfer complete |

## Verification
The bench goes after the switch points. One is an MWI burst that runs down to its last partial line: if the remaining bytes were compared after the boundary instead of at it, the block would keep MWI on a short tail. Another is an MW burst that starts unaligned and reaches its first boundary, where a design that never re-decides would stay on MW. Early terminations on every phase force decisions at unaligned restart addresses, and a design that copied the old command or raised `stop_req` there would be caught. Line size codes that are not supported and a cleared enable bit check that MWI never appears.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int PHASE_BYTES     = 4;
  localparam int MIN_LINE_WORDS  = 4;
  localparam int NUM_LINE_SIZES  = 4;
  localparam int MAX_LINE_BYTES  = MIN_LINE_WORDS * PHASE_BYTES * (1 << (NUM_LINE_SIZES - 1));
  localparam int LB_W            = $clog2(MAX_LINE_BYTES) + 1;

  typedef enum logic {
    WR_PLAIN = 1'b0,
    WR_INVAL = 1'b1
  } wr_cmd_e;

  typedef enum logic {
    TRK_IDLE   = 1'b0,
    TRK_ACTIVE = 1'b1
  } trk_state_e;
endpackage

// File: rtl/mwc_line_decode.sv
module mwc_line_decode
  import mwc_pkg::*;
#(
  parameter int CLS_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [CLS_W-1:0]  line_words,
  output logic              line_legal,
  output logic [LB_W-1:0]   line_bytes,
  output logic [ADDR_W-1:0] line_mask
);
  logic [NUM_LINE_SIZES-1:0] hit;

  for (genvar g = 0; g < NUM_LINE_SIZES; g++) begin : g_size
    assign hit[g] = (line_words == CLS_W'(MIN_LINE_WORDS << g));
  end

  always_comb begin
    line_bytes = '0;
    for (int i = 0; i < NUM_LINE_SIZES; i++) begin
      if (hit[i]) line_bytes = LB_W'((MIN_LINE_WORDS * PHASE_BYTES) << i);
    end
  end

  assign line_legal = |hit;
  assign line_mask  = line_legal ? (ADDR_W'(line_bytes) - ADDR_W'(1)) : '0;
endmodule

// File: rtl/mwc_cmd_decide.sv
module mwc_cmd_decide
  import mwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  rem,
  input  logic              inv_en,
  input  logic              line_legal,
  input  logic [LB_W-1:0]   line_bytes,
  input  logic [ADDR_W-1:0] line_mask,
  output wr_cmd_e           cmd
);
  logic aligned;
  logic enough;

  assign aligned = ((addr & line_mask) == '0);
  assign enough  = (rem >= LEN_W'(line_bytes));
  assign cmd     = (inv_en && line_legal && aligned && enough) ? WR_INVAL : WR_PLAIN;
endmodule

// File: rtl/mwc_burst_track.sv
module mwc_burst_track
  import mwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CLS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [CLS_W-1:0]  cfg_line_words,
  input  logic              cfg_inv_en,
  input  logic              phase_ack,
  input  logic              early_term,
  input  wr_cmd_e           dec_cmd,
  input  logic              line_legal,
  input  logic [LB_W-1:0]   line_bytes,
  input  logic [ADDR_W-1:0] line_mask,
  output logic [ADDR_W-1:0] eval_addr,
  output logic [LEN_W-1:0]  eval_rem,
  output logic [CLS_W-1:0]  eval_cls,
  output logic              eval_inv,
  output logic              busy,
  output logic              burst_start,
  output logic [ADDR_W-1:0] burst_addr,
  output wr_cmd_e           cmd,
  output logic              stop_req,
  output logic              xfer_done
);
  localparam int STEP_SH = $clog2(PHASE_BYTES);

  trk_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CLS_W-1:0]  cls_q;
  logic              inv_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [LEN_W-1:0]  rem_nx;
  logic [ADDR_W-1:0] req_addr_w;
  logic [LEN_W-1:0]  req_bytes_w;
  logic              at_boundary;

  assign addr_nx     = addr_q + ADDR_W'(PHASE_BYTES);
  assign rem_nx      = rem_q - LEN_W'(PHASE_BYTES);
  assign req_addr_w  = {req_addr[ADDR_W-1:STEP_SH], STEP_SH'(0)};
  assign req_bytes_w = {req_bytes[LEN_W-1:STEP_SH], STEP_SH'(0)};
  assign at_boundary = line_legal && ((addr_nx & line_mask) == '0);

  // Idle: judge the incoming request with live configuration.
  // Active: judge the next address with the configuration latched at request.
  always_comb begin
    if (state_q == TRK_ACTIVE) begin
      eval_addr = addr_nx;
      eval_rem  = rem_nx;
      eval_cls  = cls_q;
      eval_inv  = inv_q;
    end else begin
      eval_addr = req_addr_w;
      eval_rem  = req_bytes_w;
      eval_cls  = cfg_line_words;
      eval_inv  = cfg_inv_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= TRK_IDLE;
      addr_q      <= '0;
      rem_q       <= '0;
      cls_q       <= '0;
      inv_q       <= 1'b0;
      busy        <= 1'b0;
      burst_start <= 1'b0;
      burst_addr  <= '0;
      cmd         <= WR_PLAIN;
      stop_req    <= 1'b0;
      xfer_done   <= 1'b0;
    end else begin
      burst_start <= 1'b0;
      stop_req    <= 1'b0;
      xfer_done   <= 1'b0;
      unique case (state_q)
        TRK_IDLE: begin
          if (req_valid) begin
            cls_q <= cfg_line_words;
            inv_q <= cfg_inv_en;
            if (req_bytes_w == '0) begin
              xfer_done <= 1'b1;
            end else begin
              state_q     <= TRK_ACTIVE;
              busy        <= 1'b1;
              addr_q      <= req_addr_w;
              rem_q       <= req_bytes_w;
              burst_start <= 1'b1;
              burst_addr  <= req_addr_w;
              cmd         <= dec_cmd;
            end
          end
        end
        TRK_ACTIVE: begin
          if (phase_ack) begin
            addr_q <= addr_nx;
            rem_q  <= rem_nx;
            if (rem_nx == '0) begin
              state_q   <= TRK_IDLE;
              busy      <= 1'b0;
              xfer_done <= 1'b1;
            end else if (early_term) begin
              burst_start <= 1'b1;
              burst_addr  <= addr_nx;
              cmd         <= dec_cmd;
            end else if (at_boundary && (dec_cmd != cmd)) begin
              stop_req    <= 1'b1;
              burst_start <= 1'b1;
              burst_addr  <= addr_nx;
              cmd         <= dec_cmd;
            end
          end
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  // R1: an unsupported line size never yields the invalidate command
  assert_bad_size_plain_R1: assert property (@(posedge clk) disable iff (rst)
    (burst_start && !line_legal) |-> (cmd == WR_PLAIN));

  // R2: invalidate disabled at request means plain writes only
  assert_inv_off_plain_R2: assert property (@(posedge clk) disable iff (rst)
    (burst_start && !inv_q) |-> (cmd == WR_PLAIN));

  // R3: an invalidate burst starts on a line and has a full line ahead
  assert_inval_fits_R3: assert property (@(posedge clk) disable iff (rst)
    (burst_start && cmd == WR_INVAL) |->
      (((burst_addr & line_mask) == '0) && (rem_q >= LEN_W'(line_bytes))));

  // R5: a stop request always comes with the restart announcement
  assert_stop_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> (burst_start && busy));

  // R7: a target-ended burst restarts without a stop request
  assert_term_no_stop_R7: assert property (@(posedge clk) disable iff (rst)
    $past(busy && phase_ack && early_term) |-> !stop_req);

  // R8: completion leaves the block idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!busy && !burst_start));

  // R9: command and burst address hold between burst starts
  assert_cmd_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !burst_start) |-> ($stable(cmd) && $stable(burst_addr)));

  // R11: a phase strobe while idle has no effect
  assert_idle_ack_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!busy && !req_valid && phase_ack) |-> (!burst_start && !xfer_done));
endmodule

// File: rtl/mwc_cmd_select.sv
module mwc_cmd_select
  import mwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CLS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [CLS_W-1:0]  cfg_line_words,
  input  logic              cfg_inv_en,
  input  logic              phase_ack,
  input  logic              early_term,
  output logic              busy,
  output logic              burst_start,
  output logic [ADDR_W-1:0] burst_addr,
  output logic              cmd_inv,
  output logic              stop_req,
  output logic              xfer_done
);
  logic [ADDR_W-1:0] eval_addr;
  logic [LEN_W-1:0]  eval_rem;
  logic [CLS_W-1:0]  eval_cls;
  logic              eval_inv;
  logic              line_legal;
  logic [LB_W-1:0]   line_bytes;
  logic [ADDR_W-1:0] line_mask;
  wr_cmd_e           dec_cmd;
  wr_cmd_e           cmd_q;

  mwc_line_decode #(.CLS_W(CLS_W), .ADDR_W(ADDR_W)) u_line (
    .line_words (eval_cls),
    .line_legal (line_legal),
    .line_bytes (line_bytes),
    .line_mask  (line_mask)
  );

  mwc_cmd_decide #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decide (
    .addr       (eval_addr),
    .rem        (eval_rem),
    .inv_en     (eval_inv),
    .line_legal (line_legal),
    .line_bytes (line_bytes),
    .line_mask  (line_mask),
    .cmd        (dec_cmd)
  );

  mwc_burst_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLS_W(CLS_W)) u_track (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_bytes      (req_bytes),
    .cfg_line_words (cfg_line_words),
    .cfg_inv_en     (cfg_inv_en),
    .phase_ack      (phase_ack),
    .early_term     (early_term),
    .dec_cmd        (dec_cmd),
    .line_legal     (line_legal),
    .line_bytes     (line_bytes),
    .line_mask      (line_mask),
    .eval_addr      (eval_addr),
    .eval_rem       (eval_rem),
    .eval_cls       (eval_cls),
    .eval_inv       (eval_inv),
    .busy           (busy),
    .burst_start    (burst_start),
    .burst_addr     (burst_addr),
    .cmd            (cmd_q),
    .stop_req       (stop_req),
    .xfer_done      (xfer_done)
  );

  assign cmd_inv = (cmd_q == WR_INVAL);
endmodule

// File: tb/test_mwc_cmd_select.sv
`timescale 1ns/1ps
module test_mwc_cmd_select;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_bytes = '0;
  logic [CW-1:0] cfg_line_words = '0;
  logic          cfg_inv_en = 1'b0;
  logic          phase_ack = 1'b0;
  logic          early_term = 1'b0;
  logic          busy, burst_start, cmd_inv, stop_req, xfer_done;
  logic [AW-1:0] burst_addr;

  always #2 clk = ~clk;

  mwc_cmd_select #(.ADDR_W(AW), .LEN_W(LW), .CLS_W(CW)) i_mwc_cmd_select (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .cfg_line_words(cfg_line_words), .cfg_inv_en(cfg_inv_en),
    .phase_ack(phase_ack), .early_term(early_term), .busy(busy),
    .burst_start(burst_start), .burst_addr(burst_addr), .cmd_inv(cmd_inv),
    .stop_req(stop_req), .xfer_done(xfer_done)
  );

  typedef struct {
    bit          fin;
    logic [31:0] addr;
    bit          inv;
    bit          stop;
    string       rq;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   mon_en = 1'b0;
  bit   prev_busy = 1'b0;
  bit   last_inv;
  logic [31:0] last_addr;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit size_ok(input int cls);
    return (cls == 4) || (cls == 8) || (cls == 16) || (cls == 32);
  endfunction

  function automatic bit ref_dec(input logic [31:0] a, input int r, input int cls, input bit en);
    int lb;
    lb = cls * 4;
    return en && size_ok(cls) && ((a & (lb - 1)) == 0) && (r >= lb);
  endfunction

  // Driver: model the transfer line by line, queue expectations, then drive it.
  task automatic run_xfer(input logic [31:0] a0, input int nbytes, input int cls,
                          input bit en, input int term_pct, input int gap_pct);
    int          np;
    int          r;
    logic [31:0] a;
    bit          c, nc;
    bit          term[];
    exp_t        e;
    np = nbytes / 4;
    term = new[np > 0 ? np : 1];
    a = a0 & 32'hffff_fffc;
    r = np * 4;
    if (np == 0) begin
      e = '{1'b1, 32'h0, 1'b0, 1'b0, "R8"};
      q.push_back(e);
    end else begin
      c = ref_dec(a, r, cls, en);
      e = '{1'b0, a, c, 1'b0, !size_ok(cls) ? "R1" : (!en ? "R2" : (c ? "R3" : "R4"))};
      q.push_back(e);
      for (int i = 0; i < np; i++) begin
        term[i] = (($urandom % 100) < term_pct);
        a += 4;
        r -= 4;
        if (r == 0) begin
          e = '{1'b1, 32'h0, 1'b0, 1'b0, "R8"};
          q.push_back(e);
        end else if (term[i]) begin
          c = ref_dec(a, r, cls, en);
          e = '{1'b0, a, c, 1'b0, "R7"};
          q.push_back(e);
        end else if (size_ok(cls) && ((a & (cls * 4 - 1)) == 0)) begin
          nc = ref_dec(a, r, cls, en);
          if (nc != c) begin
            e = '{1'b0, a, nc, 1'b1, c ? "R5" : "R6"};
            q.push_back(e);
            c = nc;
          end
        end
      end
    end
    @(negedge clk);
    req_valid      = 1'b1;
    req_addr       = a0;
    req_bytes      = LW'(nbytes);
    cfg_line_words = CW'(cls);
    cfg_inv_en     = en;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < np; i++) begin
      while (($urandom % 100) < gap_pct) @(negedge clk);
      phase_ack  = 1'b1;
      early_term = term[i];
      @(negedge clk);
      phase_ack  = 1'b0;
      early_term = 1'b0;
    end
    @(negedge clk);
  endtask

  // R11: phase strobes while idle must leave the outputs quiet
  task automatic idle_acks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase_ack = 1'b1;
      @(negedge clk);
      phase_ack = 1'b0;
      check(!burst_start && !xfer_done && !busy, "R11", "idle strobe effect",
            {29'b0, busy, burst_start, xfer_done}, 32'h0);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (stop_req && !burst_start)
        check(1'b0, "R5", "stop without restart", 32'h1, 32'h0);
      if (busy && prev_busy && !burst_start)
        check(cmd_inv == last_inv && burst_addr == last_addr, "R9", "held burst fields",
              burst_addr, last_addr);
      if (burst_start || xfer_done) begin
        if (q.size() == 0) begin
          check(1'b0, "R11", "unexpected event", {30'b0, burst_start, xfer_done}, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.fin) begin
            check(xfer_done && !burst_start && !busy, "R8", "completion",
                  {29'b0, xfer_done, burst_start, busy}, 32'h4);
          end else begin
            check(burst_start, e.rq, "burst start", {31'b0, burst_start}, 32'h1);
            check(burst_addr == e.addr, e.rq, "burst address", burst_addr, e.addr);
            check(cmd_inv == e.inv, e.rq, "command", {31'b0, cmd_inv}, {31'b0, e.inv});
            check(stop_req == e.stop, e.rq, "stop request", {31'b0, stop_req}, {31'b0, e.stop});
          end
        end
      end
      if (burst_start) begin
        last_inv  = cmd_inv;
        last_addr = burst_addr;
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !burst_start && !stop_req && !xfer_done && !cmd_inv, "R10", "reset outputs",
          {27'b0, busy, burst_start, stop_req, xfer_done, cmd_inv}, 32'h0);
    mon_en = 1'b1;
    idle_acks(3);
    run_xfer(32'h1000, 256, 16, 1'b1, 0, 0);   // R3 full MWI
    run_xfer(32'h1000, 100, 8, 1'b1, 0, 0);    // R5 tail switches to MW
    run_xfer(32'h1004, 64, 4, 1'b1, 0, 0);     // R4 then R6
    run_xfer(32'h2000, 12, 4, 1'b1, 0, 0);     // R4 short aligned
    run_xfer(32'h2000, 256, 16, 1'b0, 0, 0);   // R2
    run_xfer(32'h3000, 256, 0, 1'b1, 0, 0);    // R1 size 0
    run_xfer(32'h3000, 256, 12, 1'b1, 0, 0);   // R1 size 12
    run_xfer(32'h4000, 32, 4, 1'b1, 100, 0);   // R7 every phase terminates
    run_xfer(32'h5000, 0, 8, 1'b1, 0, 0);      // R8 zero count
    run_xfer(32'h5000, 70, 4, 1'b1, 0, 30);    // R8 low bits ignored, gaps
    idle_acks(2);
    for (int n = 0; n < 300; n++) begin
      int cls_tab[8];
      logic [31:0] a;
      cls_tab = '{4, 8, 16, 32, 0, 12, 64, 2};
      a = $urandom & 32'h0000_fffc;
      if ($urandom % 2) a = a & 32'hffff_ff80;
      run_xfer(a, 4 * (1 + ($urandom % 96)), cls_tab[($urandom % 8 < 6) ? $urandom % 4 : $urandom % 8],
               ($urandom % 4) != 0, ($urandom % 2) ? 10 : 0, 20);
    end
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R8", "leftover expectations", q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule